// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is a seven-pin general-purpose I/O port driven from a small register bus. Software sees three registers: a direction register that chooses, per pin, whether the output driver is enabled; an output data latch that holds the value to drive; and a pin-level register that returns what the pads actually carry. The latch can be written through either the pin-level address or the latch address. It can also be read back on its own, so a read-modify-write never picks up a level that a loaded pin has pulled away from the driven value.

Pads are modelled as separate input, output and output-enable vectors. Bit 4 is an open-drain pin that can only pull low, and its synchronised level also goes to a timer as a clock input. Bits 0 to 3 and bit 5 can be put into analog mode by an external per-pin select vector. In that mode they read as zero through the pin-level register, and the direction register still controls their drivers. Every pin level passes through a two-flop synchroniser before it reaches the read path and the peripheral taps.

Top module: `gpio_port`

## Requirements
- R1: On every pin except bit 4, a direction bit of 1 leaves `pin_oe` low, and a direction bit of 0 raises `pin_oe` and puts the latch bit on `pin_o`.
- R2: A write with `wr_en` high to address 0 (pin level) or address 1 (latch) loads `wr_data` into the output latch on that clock edge.
- R3: Reads are combinational. Address 0 returns the synchronised pin levels, address 1 the latch, address 2 the direction register, and address 3 returns zero.
- R4: Reset (`rst_n` low, synchronous) sets all direction bits to 1 and clears the latch, so no pin is driven.
- R5: Pin 4 never drives high: `pin_o[4]` is always 0, and `pin_oe[4]` is high only when direction bit 4 and latch bit 4 are both 0.
- R6: `tmr_clk` carries the synchronised level of pin 4.
- R7: When `ana_sel` is set for bit 0, 1, 2, 3 or 5, that bit reads 0 at address 0. `ana_sel` bits 4 and 6 have no effect. Analog mode leaves `pin_oe` and `pin_o` unchanged.
- R8: A pin change becomes visible at address 0 and on `tap` after the second rising edge following it, not after the first. `tap` is not masked by analog mode.
- R9: A bus cycle with `wr_en` low, and a write to address 3, change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 pin level, 1 latch, 2 direction |
| wr_data | input | 7 | Write data |
| rd_data | output | 7 | Combinational read data of the selected register |
| ana_sel | input | 7 | Per-pin analog mode select (honoured on bits 0-3, 5) |
| pin_i | input | 7 | Pad input levels |
| pin_o | output | 7 | Pad output values |
| pin_oe | output | 7 | Pad output enables, active high |
| tap | output | 7 | Synchronised pin levels for peripherals |
| tmr_clk | output | 1 | Synchronised level of pin 4 for a timer |

## Verification
A corrupted direction or latch bit shows on `pin_oe` or `pin_o` one edge after the write that set it. It shows at once on a read of address 1 or 2, because these reads are combinational. A synchroniser fault, such as a missing or extra stage, moves the point at which address 0 and `tap` follow a pin change. The bench therefore samples both after exactly one edge and after exactly two. A wrong analog mask turns up as a stray one or a stray zero in a pin-level read while `ana_sel` is all ones.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_PINS  = 2'd0,
        RA_LATCH = 2'd1,
        RA_DIR   = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.s2;

    // R8: the second stage takes over what the first stage held one edge earlier
    a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 == $past(st_q.s1));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      lat_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            unique case (addr_i)
                RA_PINS, RA_LATCH: rg_d.lat = wr_data;
                RA_DIR:            rg_d.dir = wr_data;
                default:           rg_d     = rg_q;
            endcase
        end
        if (!rst_n) begin
            rg_d.dir = '1;
            rg_d.lat = '0;
        end
    end

    always_ff @(posedge clk) begin
        rg_q <= rg_d;
    end

    assign dir_o = rg_q.dir;
    assign lat_o = rg_q.lat;

    // R9: with no write strobe, neither register moves
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rg_q == $past(rg_q)));

    // R2: a latch-path write is reflected in the latch one edge later
    a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr_i == RA_PINS || addr_i == RA_LATCH)) |=> (lat_o == $past(wr_data)));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int W      = 7,
    parameter int OD_BIT = 4
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] lat_i,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == OD_BIT) begin : g_od
            assign pin_o[i]  = 1'b0;
            assign pin_oe[i] = ~dir_i[i] & ~lat_i[i];
        end else begin : g_pp
            assign pin_o[i]  = lat_i[i];
            assign pin_oe[i] = ~dir_i[i];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int           W        = 7,
    parameter int           OD_BIT   = 4,
    parameter logic [W-1:0] ANA_MASK = 7'b0101111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      ana_sel,
    input  logic [W-1:0]      pin_i,
    output logic [W-1:0]      pin_o,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      tap,
    output logic              tmr_clk
);
    localparam logic [W-1:0] OD_MASK = {{(W-1){1'b0}}, 1'b1} << OD_BIT;

    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] ana_eff;

    gpio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr_i  (addr),
        .wr_data (wr_data),
        .dir_o   (dir_q),
        .lat_o   (lat_q)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (lvl_q)
    );

    gpio_drive #(.W(W), .OD_BIT(OD_BIT)) u_drive (
        .dir_i  (dir_q),
        .lat_i  (lat_q),
        .pin_o  (pin_o),
        .pin_oe (pin_oe)
    );

    assign ana_eff = ana_sel & ANA_MASK;
    assign tap     = lvl_q;
    assign tmr_clk = lvl_q[OD_BIT];

    always_comb begin
        unique case (addr)
            RA_PINS:  rd_data = lvl_q & ~ana_eff;
            RA_LATCH: rd_data = lat_q;
            RA_DIR:   rd_data = dir_q;
            default:  rd_data = '0;
        endcase
    end

    // R1: a direction write sets the push-pull enables on the next edge
    a_r1_dir_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DIR) |=> ((pin_oe & ~OD_MASK) == (~$past(wr_data) & ~OD_MASK)));

    // R4: coming out of reset no pad is driven
    a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0));

    // R5: a latch-path write with a one on the open-drain bit releases that pad
    a_r5_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == RA_PINS || addr == RA_LATCH) && wr_data[OD_BIT])
            |=> !pin_oe[OD_BIT]);

    // R5: the open-drain pad never presents a high value
    a_r5_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[OD_BIT] |-> !pin_o[OD_BIT]);
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/100ps
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [6:0] wr_data = '0;
    logic [6:0] rd_data;
    logic [6:0] ana_sel = '0;
    logic [6:0] pin_i = '0;
    logic [6:0] pin_o;
    logic [6:0] pin_oe;
    logic [6:0] tap;
    logic       tmr_clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ana_sel(ana_sel),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .tap(tap),
        .tmr_clk(tmr_clk)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [6:0] exp);
        addr = a;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rd_chk("R4 dir reset", 2'd2, 7'h7F);
        rd_chk("R4 latch reset", 2'd1, 7'h00);
        chk("R4 no drive", pin_oe, 7'h00);
    endtask

    task automatic t_drive;
        wr(2'd2, 7'h00);
        wr(2'd0, 7'h55);
        chk("R2 pin addr write", pin_o, 7'h55 & 7'h6F);
        chk("R1 R5 enables", pin_oe, 7'h6F);
        chk("R5 od pin low", {6'd0, pin_o[4]}, 7'h00);
        wr(2'd1, 7'h2A);
        rd_chk("R2 latch addr write", 2'd1, 7'h2A);
        chk("R5 od pull low", pin_oe, 7'h7F);
        wr(2'd2, 7'h11);
        chk("R1 R5 inputs released", pin_oe, 7'h6E);
    endtask

    task automatic t_reads;
        @(negedge clk);
        ana_sel = '0; pin_i = 7'h5A;
        @(negedge clk);
        rd_chk("R8 not after one edge", 2'd0, 7'h00);
        @(negedge clk);
        rd_chk("R3 R8 pin read", 2'd0, 7'h5A);
        chk("R8 tap", tap, 7'h5A);
        chk("R6 timer clock", {6'd0, tmr_clk}, 7'h01);
        rd_chk("R3 latch read independent of pins", 2'd1, 7'h2A);
        rd_chk("R3 unused address", 2'd3, 7'h00);
    endtask

    task automatic t_analog;
        @(negedge clk);
        pin_i = 7'h7F; ana_sel = 7'h7F;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R7 analog masks", 2'd0, 7'h50);
        chk("R8 tap unmasked", tap, 7'h7F);
        chk("R7 drivers unchanged", pin_oe, 7'h6E);
        pin_i = 7'h2F;
        @(negedge clk);
        @(negedge clk);
        chk("R6 timer clock low", {6'd0, tmr_clk}, 7'h00);
        ana_sel = '0;
        pin_i = 7'h00;
    endtask

    task automatic t_ignore;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd1; wr_data = 7'h7F;
        @(negedge clk);
        rd_chk("R9 no strobe latch", 2'd1, 7'h2A);
        wr(2'd3, 7'h7F);
        rd_chk("R9 addr3 latch", 2'd1, 7'h2A);
        rd_chk("R9 addr3 dir", 2'd2, 7'h11);
    endtask

    initial begin
        #10000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_drive();
        t_reads();
        t_analog();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule